// File: doc/BRIEF.md
# Geometry Triangle Emit Assembler

This block sits behind a geometry-shading unit and turns its emit commands into a stream of triangles. It holds three vertex slots. Each accepted emit command writes the shader's current output word into the slot picked by a two-bit vertex id. When the command also carries the primitive flag, the assembler sends the three slots downstream as one triangle. The data that command writes is included in that triangle.

The triangle leaves as three beats on a valid/ready channel, and the third beat carries a last marker. A winding bit taken from the releasing command selects ascending slot order (0, 1, 2) or descending slot order (2, 1, 0). Slots keep their contents until they are written again, so strips and fans can reuse vertices stored earlier. While a triangle is pending, the emit side reports not-ready so the slots cannot change under the output. A vertex id outside the slot range stores nothing, releases nothing and raises a one-cycle error pulse.

Top module: `tri_emit_asm`

## Requirements
- R1: After reset, tri_valid, emit_err and tri_last are 0, emit_ready is 1, and all three slots hold zero.
- R2: An emit command is accepted on a rising clock edge where emit_valid and emit_ready are both 1. If emit_vid is 0, 1 or 2, emit_data is stored into that slot.
- R3: A triangle is started only by an accepted command with a legal id and emit_prim = 1. tri_valid is 1 in the cycle after the acceptance, and the triangle contains the data stored by that same command.
- R4: With emit_wind = 0 on the releasing command, the beats carry slots 0, 1, 2 in that order.
- R5: With emit_wind = 1 on the releasing command, the beats carry slots 2, 1, 0 in that order.
- R6: A slot keeps its value across emits that do not write it, and later triangles reuse that value.
- R7: An accepted command with emit_vid = 3 writes no slot and starts no triangle, even when emit_prim = 1. emit_err is 1 for exactly the cycle after that acceptance.
- R8: While tri_valid is 1, emit_ready is 0. While tri_valid is 1 and tri_ready is 0, tri_valid, tri_data and tri_last hold their values into the next cycle.
- R9: Each triangle is exactly three beats, one per cycle in which tri_valid and tri_ready are both 1. tri_last is 1 only on the third beat, and tri_valid falls after that beat unless a new triangle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| emit_valid | input | 1 | Emit command present |
| emit_ready | output | 1 | Emit command can be accepted |
| emit_vid | input | 2 | Target slot id (0 to 2 legal) |
| emit_prim | input | 1 | Release a triangle after this store |
| emit_wind | input | 1 | Winding: 0 ascending, 1 descending slot order |
| emit_data | input | VTX_W | Current shader output word |
| emit_err | output | 1 | One-cycle pulse after an emit with an illegal id |
| tri_valid | output | 1 | Triangle beat present |
| tri_ready | input | 1 | Downstream accepts the beat |
| tri_data | output | VTX_W | Vertex data of the current beat |
| tri_last | output | 1 | Marks the third beat of a triangle |

## Verification
Every result comes one register stage after the edge that accepts the command. tri_valid and the first beat appear right after that edge, and emit_err pulses in that same following cycle. Each further beat follows one cycle after the previous handshake. The bench drives inputs on the falling edge and checks results one time unit later. A per-command check therefore looks exactly one cycle past acceptance. A scoreboard checks beat data and last flags against a slot model, in the order of the handshakes and under both steady and randomly stalling tri_ready.

// File: rtl/tri_emit_pkg.sv
package tri_emit_pkg;
  localparam int NUM_SLOTS = 3;
  localparam int SLOT_IW   = 2;
  localparam int BEAT_W    = 2;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUM_SLOTS - 1);

  // Slot read on a given beat for the latched winding.
  function automatic logic [SLOT_IW-1:0] beat_slot(input logic [BEAT_W-1:0] beat,
                                                   input logic wind);
    return wind ? SLOT_IW'(LAST_BEAT - beat) : SLOT_IW'(beat);
  endfunction

  function automatic logic id_legal(input logic [SLOT_IW-1:0] vid);
    return vid < SLOT_IW'(NUM_SLOTS);
  endfunction
endpackage

// File: rtl/tri_emit_slots.sv
module tri_emit_slots
  import tri_emit_pkg::*;
#(
  parameter int VTX_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_IW-1:0] wr_idx,
  input  logic [VTX_W-1:0]   wr_data,
  input  logic [SLOT_IW-1:0] rd_idx,
  output logic [VTX_W-1:0]   rd_data
);
  logic [VTX_W-1:0] slot_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_idx == SLOT_IW'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_idx == SLOT_IW'(i)) rd_data = slot_q[i];
    end
  end

  AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < SLOT_IW'(NUM_SLOTS))); // R7
endmodule

// File: rtl/tri_emit_seq.sv
module tri_emit_seq
  import tri_emit_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               emit_valid,
  input  logic [SLOT_IW-1:0] emit_vid,
  input  logic               emit_prim,
  input  logic               emit_wind,
  output logic               emit_ready,
  input  logic               tri_ready,
  output logic               wr_en,
  output logic [SLOT_IW-1:0] wr_idx,
  output logic [SLOT_IW-1:0] rd_idx,
  output logic               tri_valid,
  output logic               tri_last,
  output logic               emit_err
);
  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;
  logic              wind_q;
  logic              err_q;

  // Named internal events
  logic emit_fire, vid_good, tri_start, beat_fire, tri_done;
  assign emit_fire = emit_valid && !busy_q;
  assign vid_good  = id_legal(emit_vid);
  assign tri_start = emit_fire && vid_good && emit_prim;
  assign beat_fire = busy_q && tri_ready;
  assign tri_done  = beat_fire && (beat_q == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      wind_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= emit_fire && !vid_good;
      if (tri_start) begin
        busy_q <= 1'b1;
        beat_q <= '0;
        wind_q <= emit_wind;
      end else if (tri_done) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else if (beat_fire) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign emit_ready = !busy_q;
  assign wr_en      = emit_fire && vid_good;
  assign wr_idx     = emit_vid;
  assign rd_idx     = beat_slot(beat_q, wind_q);
  assign tri_valid  = busy_q;
  assign tri_last   = busy_q && (beat_q == LAST_BEAT);
  assign emit_err   = err_q;

  AST_START_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tri_start |=> (tri_valid && !tri_last && rd_idx == beat_slot('0, $past(emit_wind)))); // R3
  AST_LAST_ENDS_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_valid && tri_ready && tri_last) |=> !tri_valid); // R9
  AST_ERR_NO_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    emit_err |-> !tri_valid); // R7
endmodule

// File: rtl/tri_emit_asm.sv
module tri_emit_asm
  import tri_emit_pkg::*;
#(
  parameter int VTX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit_valid,
  output logic             emit_ready,
  input  logic [1:0]       emit_vid,
  input  logic             emit_prim,
  input  logic             emit_wind,
  input  logic [VTX_W-1:0] emit_data,
  output logic             emit_err,
  output logic             tri_valid,
  input  logic             tri_ready,
  output logic [VTX_W-1:0] tri_data,
  output logic             tri_last
);
  logic               wr_en;
  logic [SLOT_IW-1:0] wr_idx;
  logic [SLOT_IW-1:0] rd_idx;

  tri_emit_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .emit_valid (emit_valid),
    .emit_vid   (emit_vid),
    .emit_prim  (emit_prim),
    .emit_wind  (emit_wind),
    .emit_ready (emit_ready),
    .tri_ready  (tri_ready),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .tri_valid  (tri_valid),
    .tri_last   (tri_last),
    .emit_err   (emit_err)
  );

  tri_emit_slots #(.VTX_W(VTX_W)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (emit_data),
    .rd_idx  (rd_idx),
    .rd_data (tri_data)
  );

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_valid && !tri_ready) |=> (tri_valid && $stable(tri_data) && $stable(tri_last))); // R8
endmodule

// File: tb/tri_emit_asm_tb.sv
module tri_emit_asm_tb;
  localparam int VTX_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             emit_valid = 1'b0;
  logic             emit_ready;
  logic [1:0]       emit_vid = '0;
  logic             emit_prim = 1'b0;
  logic             emit_wind = 1'b0;
  logic [VTX_W-1:0] emit_data = '0;
  logic             emit_err;
  logic             tri_valid;
  logic             tri_ready = 1'b1;
  logic [VTX_W-1:0] tri_data;
  logic             tri_last;

  always #4 clk = ~clk; // 125 MHz

  tri_emit_asm #(.VTX_W(VTX_W)) u_dut (.*);

  int checks = 0;
  int fails  = 0;
  logic [VTX_W-1:0] model [3];
  logic [VTX_W-1:0] q_data [$];
  logic             q_last [$];
  string            q_req  [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: issues one emit command and queues the expected beats.
  task automatic do_emit(input logic [1:0] vid, input bit prim, input bit wind,
                         input logic [VTX_W-1:0] d, input string req);
    @(negedge clk);
    while (!emit_ready) @(negedge clk);
    emit_valid = 1'b1; emit_vid = vid; emit_prim = prim; emit_wind = wind; emit_data = d;
    if (vid < 2'd3) begin
      model[vid] = d;
      if (prim) begin
        for (int b = 0; b < 3; b++) begin
          q_data.push_back(model[wind ? 2 - b : b]);
          q_last.push_back(b == 2);
          q_req.push_back(req);
        end
      end
    end
    @(negedge clk);
    emit_valid = 1'b0;
    if (vid == 2'd3) begin
      check(emit_err == 1'b1, "R7 err pulse", 64'(emit_err), 64'd1);
      check(tri_valid == 1'b0, "R7 no triangle", 64'(tri_valid), 64'd0);
      @(negedge clk);
      check(emit_err == 1'b0, "R7 err one cycle", 64'(emit_err), 64'd0);
    end else begin
      check(tri_valid == prim, "R3 start timing", 64'(tri_valid), 64'(prim));
    end
  endtask

  // Monitor / scoreboard
  bit               prev_stall = 1'b0;
  logic [VTX_W-1:0] prev_data;
  logic             prev_last;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_stall) begin
        check(tri_valid && tri_data == prev_data && tri_last == prev_last,
              "R8 hold under stall", 64'(tri_data), 64'(prev_data));
      end
      if (tri_valid) check(!emit_ready, "R8 emit blocked", 64'(emit_ready), 64'd0);
      if (tri_valid && tri_ready) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R9 unexpected beat", 64'(tri_data), 64'd0);
        end else begin
          logic [VTX_W-1:0] ed;
          logic             el;
          string            er;
          ed = q_data.pop_front(); el = q_last.pop_front(); er = q_req.pop_front();
          check(tri_data == ed, er, 64'(tri_data), 64'(ed));
          check(tri_last == el, "R9 last marker", 64'(tri_last), 64'(el));
        end
      end
      prev_stall = tri_valid && !tri_ready;
      prev_data  = tri_data;
      prev_last  = tri_last;
    end
  end

  // Ready pattern
  bit       stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tri_ready <= stall_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
  end

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic drain();
    int guard = 0;
    @(negedge clk);
    while ((q_data.size() != 0 || tri_valid) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    check(q_data.size() == 0, "R9 all beats delivered", 64'(q_data.size()), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tri_valid, "R1 tri_valid", 64'(tri_valid), 64'd0);
    check(emit_ready, "R1 emit_ready", 64'(emit_ready), 64'd1);
    check(!emit_err && !tri_last, "R1 err/last", 64'({emit_err, tri_last}), 64'd0);

    do_emit(2'd0, 1'b1, 1'b0, 32'h1111_0000, "R1 R3 zero slots plus own store"); drain();
    do_emit(2'd1, 1'b0, 1'b0, 32'h2222_0001, "R2");
    do_emit(2'd2, 1'b0, 1'b0, 32'h3333_0002, "R2");
    do_emit(2'd0, 1'b1, 1'b0, 32'h4444_0003, "R4 ascending"); drain();
    do_emit(2'd1, 1'b1, 1'b1, 32'h5555_0004, "R5 descending R6 reuse"); drain();
    do_emit(2'd3, 1'b1, 1'b0, 32'hDEAD_BEEF, "R7");
    do_emit(2'd2, 1'b1, 1'b0, 32'h6666_0005, "R7 R6 slot untouched by bad id"); drain();

    stall_mode = 1'b1;
    for (int k = 0; k < 24; k++) begin
      do_emit(2'(k % 3), (k % 2) == 1, (k % 4) == 3, 32'hA000_0000 + 32'(k * 7), "R8 R4 R5 stalled");
    end
    drain();
    stall_mode = 1'b0;
    do_emit(2'd1, 1'b1, 1'b1, 32'h7777_0006, "R5 R6 after stalls"); drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule